// File: doc/BRIEF.md
# Cartridge Bank Mapper with Free-Running Interrupt Timer

This block is the banking logic of an 8-bit console cartridge. It holds one 6-bit bank register that the CPU writes anywhere in the lower half of the cartridge program space. From that register it builds the upper address lines of the program ROM: a 16 KB low window that can be switched, and a fixed high window. It also builds the upper address lines of a 64 KB character RAM made of two 32 KB SRAMs, and the chip select for each of them.

The character lines depend on which pattern-table half the picture processor addresses. Each line is the inverted AND of PPU A12 and one character bank bit. The lower half therefore always lands on page 15, and the upper half lands on the bitwise complement of the written bank. A 12-bit counter is clocked by the CPU bus clock and has no enable. Its top bit drives an active-low interrupt request at a fixed rate. The counter is cleared only by reset and cannot be masked.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the bank register is zero, so prg_a is 2'b00 in the low window and chr_a is 4'hF in both pattern-table halves. The timer is zero and irq_n is high.
- R2: The register loads at a clock edge only when romsel_n is low, cpu_rw is low (write) and cpu_a14 is low. Data bits 7:6 become the program bank and data bits 3:0 become the character bank.
- R3: A write with cpu_a14 high, a write with romsel_n high, and a read (cpu_rw high) all leave the register unchanged.
- R4: Data bits 5:4 have no effect on any output.
- R5: prg_a equals the program bank while cpu_a14 is low, and it is 2'b11 (the last 16 KB bank) while cpu_a14 is high.
- R6: chr_a is bitwise NOT of (ppu_a12 AND character bank). This gives 4'hF while ppu_a12 is low and the complement of the bank while ppu_a12 is high.
- R7: When ppu_a_hi (PPU A15:A13) is 3'b000, exactly one chip select is low: sram_ce_n[0] when chr_a[3] is 0, and sram_ce_n[1] when chr_a[3] is 1. For any other ppu_a_hi value, both chip selects are high.
- R8: rom_oe_n is low only when romsel_n is low and cpu_rw is high. During register writes the ROM never drives the bus.
- R9: The timer advances by one on every clock edge and wraps after 4096 edges. irq_n is low exactly while timer bit 11 is set: it is high for edges 0 to 2047 after reset and low for edges 2048 to 4095.
- R10: Register writes neither stop nor delay the timer. A write landing on the same edge where the timer crosses into bit 11 both loads the register and pulls irq_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock (M2) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_a14 | input | 1 | CPU address bit 14 |
| romsel_n | input | 1 | Active-low cartridge program space select |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_d | input | 8 | CPU data bus |
| ppu_a12 | input | 1 | PPU address bit 12 (pattern-table half) |
| ppu_a_hi | input | 3 | PPU address bits 15:13 |
| prg_a | output | 2 | Program ROM address bits 15:14 |
| rom_oe_n | output | 1 | Active-low program ROM output enable |
| chr_a | output | 4 | Character RAM address bits 15:12 |
| sram_ce_n | output | 2 | Active-low chip selects of the two 32 KB SRAMs |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Bank loading and the interrupt timer can change at the same clock edge, because the timer never pauses for bus traffic. The bench places a qualifying write on the edge where its own model of the timer goes from 2047 to 2048. It then checks at the following falling edge that irq_n has gone low and that the new program and character banks appear on prg_a and chr_a. The check is repeated at the wrap point, where irq_n must return high.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int PRG_W = 2,
  parameter int CHR_W = 4,
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_a14,
  input  logic             romsel_n,
  input  logic             cpu_rw,
  input  logic [7:0]       cpu_d,
  input  logic             ppu_a12,
  input  logic [2:0]       ppu_a_hi,
  output logic [PRG_W-1:0] prg_a,
  output logic             rom_oe_n,
  output logic [CHR_W-1:0] chr_a,
  output logic [1:0]       sram_ce_n,
  output logic             irq_n
);
  localparam int BANK_W = PRG_W + CHR_W;

  logic [BANK_W-1:0] bank_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              load;
  logic              pat_sel;

  assign load = !romsel_n && !cpu_rw && !cpu_a14;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else if (load) bank_q <= {cpu_d[7 -: PRG_W], cpu_d[CHR_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else tmr_q <= tmr_q + 1'b1;
  end

  assign prg_a    = cpu_a14 ? '1 : bank_q[BANK_W-1 -: PRG_W];
  assign rom_oe_n = !(!romsel_n && cpu_rw);
  assign chr_a    = ~({CHR_W{ppu_a12}} & bank_q[CHR_W-1:0]);
  assign pat_sel  = (ppu_a_hi == 3'b000);
  assign sram_ce_n[0] = !(pat_sel && !chr_a[CHR_W-1]);
  assign sram_ce_n[1] = !(pat_sel &&  chr_a[CHR_W-1]);
  assign irq_n    = !tmr_q[TMR_W-1];
endmodule

module cart_bank_mapper_chk #(
  parameter int PRG_W = 2,
  parameter int CHR_W = 4,
  parameter int TMR_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_a14,
  input logic                   romsel_n,
  input logic                   cpu_rw,
  input logic [7:0]             cpu_d,
  input logic                   ppu_a12,
  input logic [2:0]             ppu_a_hi,
  input logic [PRG_W-1:0]       prg_a,
  input logic                   rom_oe_n,
  input logic [CHR_W-1:0]       chr_a,
  input logic [1:0]             sram_ce_n,
  input logic                   irq_n,
  input logic [PRG_W+CHR_W-1:0] bank_q,
  input logic [TMR_W-1:0]       tmr_q
);
  logic wr_ok;
  assign wr_ok = !romsel_n && !cpu_rw && !cpu_a14;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> bank_q == {$past(cpu_d[7 -: PRG_W]), $past(cpu_d[CHR_W-1:0])});
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(bank_q));
  p_fixed_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_a14 |-> prg_a == '1);
  p_low_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_a12 |-> chr_a == '1);
  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sram_ce_n) == ((ppu_a_hi == 3'b000) ? 1 : 0));
  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (!romsel_n && cpu_rw));
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tmr_q == $past(tmr_q) + 1'b1);
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !tmr_q[TMR_W-1]);
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.PRG_W(PRG_W), .CHR_W(CHR_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_a14(cpu_a14), .romsel_n(romsel_n), .cpu_rw(cpu_rw),
  .cpu_d(cpu_d), .ppu_a12(ppu_a12), .ppu_a_hi(ppu_a_hi), .prg_a(prg_a),
  .rom_oe_n(rom_oe_n), .chr_a(chr_a), .sram_ce_n(sram_ce_n), .irq_n(irq_n),
  .bank_q(bank_q), .tmr_q(tmr_q)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic clk = 0, rst_n = 0;
  logic cpu_a14 = 0, romsel_n = 1, cpu_rw = 1, ppu_a12 = 0;
  logic [7:0] cpu_d = 0;
  logic [2:0] ppu_a_hi = 0;
  logic [1:0] prg_a, sram_ce_n;
  logic [3:0] chr_a;
  logic rom_oe_n, irq_n;
  int checks = 0, errors = 0;
  int cyc;

  always #2.5 clk = ~clk;

  cart_bank_mapper dut (.clk(clk), .rst_n(rst_n), .cpu_a14(cpu_a14), .romsel_n(romsel_n),
    .cpu_rw(cpu_rw), .cpu_d(cpu_d), .ppu_a12(ppu_a12), .ppu_a_hi(ppu_a_hi), .prg_a(prg_a),
    .rom_oe_n(rom_oe_n), .chr_a(chr_a), .sram_ce_n(sram_ce_n), .irq_n(irq_n));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic a14, input logic rs_n, input logic rw, input logic [7:0] d);
    @(negedge clk);
    cpu_a14 = a14; romsel_n = rs_n; cpu_rw = rw; cpu_d = d;
    @(negedge clk);
    cpu_a14 = 0; romsel_n = 1; cpu_rw = 1; cpu_d = 0;
  endtask

  task automatic look(input logic a14, input logic a12);
    @(negedge clk);
    cpu_a14 = a14; ppu_a12 = a12; ppu_a_hi = 0;
    #1;
  endtask

  task automatic t_reset;
    look(0, 0); chk("R1 prg", prg_a, 0); chk("R1 chr lo", chr_a, 4'hF);
    look(0, 1); chk("R1 chr hi", chr_a, 4'hF);
    chk("R1 irq", irq_n, 1);
  endtask

  task automatic t_load;
    bus(0, 0, 0, 8'h83);
    look(0, 1); chk("R2 prg", prg_a, 2); chk("R2 chr", chr_a, 4'hC);
    look(1, 0); chk("R5 fixed", prg_a, 3); chk("R6 low half", chr_a, 4'hF);
    look(0, 0); chk("R6 low half again", chr_a, 4'hF);
  endtask

  task automatic t_ignored;
    bus(1, 0, 0, 8'h4F);
    bus(0, 1, 0, 8'h4F);
    bus(0, 0, 1, 8'h4F);
    look(0, 1); chk("R3 prg kept", prg_a, 2); chk("R3 chr kept", chr_a, 4'hC);
  endtask

  task automatic t_bits54;
    bus(0, 0, 0, 8'h76);
    look(0, 1); chk("R4 prg", prg_a, 1); chk("R4 chr", chr_a, 4'h9);
    bus(0, 0, 0, 8'h46);
    look(0, 1); chk("R4 prg same", prg_a, 1); chk("R4 chr same", chr_a, 4'h9);
  endtask

  task automatic t_cs;
    bus(0, 0, 0, 8'h0F);
    look(0, 1); chk("R7 bank0 on sram0", sram_ce_n, 2'b10);
    look(0, 0); chk("R7 low half on sram1", sram_ce_n, 2'b01);
    bus(0, 0, 0, 8'h07);
    look(0, 1); chk("R7 bank8 on sram1", sram_ce_n, 2'b01); chk("R6 chr", chr_a, 4'h8);
    for (int h = 1; h < 8; h++) begin
      @(negedge clk); ppu_a_hi = 3'(h); #1;
      chk("R7 none above pattern", sram_ce_n, 2'b11);
    end
    @(negedge clk); ppu_a_hi = 0;
  endtask

  task automatic t_oe;
    @(negedge clk); romsel_n = 0; cpu_rw = 1; #1; chk("R8 read", rom_oe_n, 0);
    cpu_rw = 0; #1; chk("R8 write", rom_oe_n, 1);
    romsel_n = 1; cpu_rw = 1; #1; chk("R8 unselected", rom_oe_n, 1);
  endtask

  task automatic t_coincide;
    while (cyc < 2040) @(negedge clk);
    chk("R9 early high", irq_n, 1);
    while (cyc < 2047) @(negedge clk);
    chk("R9 before 2048", irq_n, 1);
    cpu_a14 = 0; romsel_n = 0; cpu_rw = 0; cpu_d = 8'hC5;
    @(negedge clk);
    romsel_n = 1; cpu_rw = 1; cpu_d = 0; ppu_a12 = 1; #1;
    chk("R10 irq low", irq_n, 0); chk("R10 prg", prg_a, 3); chk("R10 chr", chr_a, 4'hA);
  endtask

  task automatic t_wrap;
    while (cyc < 3000) @(negedge clk);
    bus(0, 0, 0, 8'h00);
    while (cyc < 4095) @(negedge clk);
    chk("R9 still low", irq_n, 0);
    @(negedge clk); chk("R9 wrap high", irq_n, 1);
    while (cyc < 4096 + 2048) @(negedge clk);
    chk("R9 second low", irq_n, 0);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12; rst_n = 1;
    t_reset; t_load; t_ignored; t_bits54; t_cs; t_oe; t_coincide; t_wrap;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule